// File: doc/BRIEF.md
# Calendar Set-Time Validator and BCD Codec

This block sits between software-facing binary time values and a clock chip that keeps its calendar as packed BCD bytes. On the set path it takes a full four-digit year, a one-based month, day, hour, minute and second. It checks that this is a real calendar instant inside a hundred-year window starting at 1970. It then returns either an error flag or six BCD bytes ready to be written into the clock registers. The year is folded to two digits: years from 2000 on become year minus 2000, and earlier years become year minus 1900.

On the read path it takes the six BCD bytes read back from the clock registers. It returns a binary time with the year given as an offset from 1900 and the month counted from zero. A two-digit year at or below 69 is taken to mean the 2000s.

Each path has its own valid/ready handshake and a one-entry result stage. That stage is a two-state machine. In `ST_EMPTY`, `in_ready` is high, and the ACCEPT transition to `ST_FULL` fires on `in_valid`. In `ST_FULL`, `out_valid` is high and the result is held. The RELEASE transition back to `ST_EMPTY` fires on `out_ready`. The stage accepts no new input while it is full.

Top module: `cal_codec`

## Requirements
- R1: A request accepted on a clock edge (in_valid and in_ready both high) gives out_valid high after that edge, with in_ready low. The result stays stable until a clock edge with out_ready high, after which out_valid is low and in_ready is high again.
- R2: A set request with a year below 1970 or above 2069 sets set_err.
- R3: A set request with month 0 or a month above 12 sets set_err.
- R4: A set request with day 0, or a day past the month length, sets set_err. Month lengths are 31 for months 1, 3, 5, 7, 8, 10 and 12; 30 for months 4, 6, 9 and 11; 28 for month 2.
- R5: February has 29 days in a leap year. A leap year is divisible by 400, or divisible by 4 but not by 100.
- R6: A set request with hour ≥ 24, minute ≥ 60 or second ≥ 60 sets set_err.
- R7: A legal set request clears set_err. Each output byte holds the field in packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0. The year byte holds year−2000 for years ≥ 2000 and year−1900 otherwise.
- R8: When set_err is set, all six BCD output bytes are zero.
- R9: On the read path, each byte is decoded from packed BCD. A decoded year of 69 or less gains 100, giving the offset from 1900. The decoded month is reduced by one.
- R10: The read path ignores bits above each field's tens digit. These are bit 7 of seconds and minutes, bits 7:6 of hours and days, and bits 7:5 of the month.
- R11: After reset, both paths show out_valid low and in_ready high, and the set outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_in_valid | input | 1 | Set request present |
| set_in_ready | output | 1 | Set path can accept a request |
| set_year | input | 12 | Full binary year |
| set_month | input | 4 | Month, 1 to 12 |
| set_day | input | 5 | Day of month |
| set_hour | input | 5 | Hour, 0 to 23 |
| set_minute | input | 6 | Minute |
| set_second | input | 6 | Second |
| set_out_valid | output | 1 | Set result present |
| set_out_ready | input | 1 | Consumer takes the set result |
| set_err | output | 1 | Requested time is illegal |
| bcd_year | output | 8 | Two-digit year, BCD |
| bcd_month | output | 8 | Month, BCD |
| bcd_day | output | 8 | Day, BCD |
| bcd_hour | output | 8 | Hour, BCD |
| bcd_minute | output | 8 | Minute, BCD |
| bcd_second | output | 8 | Second, BCD |
| rd_in_valid | input | 1 | Readback bytes present |
| rd_in_ready | output | 1 | Read path can accept bytes |
| rd_year_bcd | input | 8 | Stored year byte |
| rd_month_bcd | input | 8 | Stored month byte |
| rd_day_bcd | input | 8 | Stored day byte |
| rd_hour_bcd | input | 8 | Stored hour byte |
| rd_minute_bcd | input | 8 | Stored minute byte |
| rd_second_bcd | input | 8 | Stored second byte |
| rd_out_valid | output | 1 | Decoded time present |
| rd_out_ready | input | 1 | Consumer takes the decoded time |
| rd_year_off | output | 8 | Year minus 1900 |
| rd_month0 | output | 4 | Zero-based month |
| rd_day | output | 5 | Day of month |
| rd_hour | output | 5 | Hour |
| rd_minute | output | 6 | Minute |
| rd_second | output | 6 | Second |

## Verification
The bench builds the block with its default parameters: a 1970 window start, a 1900 epoch and a 12-bit year. This places both window edges (1969/1970 and 2069/2070) and the century fold at 1999/2000 within directed cases. The 2000 leap day falls inside the window, so the divisible-by-400 branch of the leap rule is exercised next to an ordinary leap year (1972) and a non-leap year (2001). On the read path, the two-digit pivot at 69/70 and the masking of bits above each tens digit are each driven with dedicated byte patterns.

// File: rtl/cal_pkg.sv
package cal_pkg;

    parameter int YEAR_W = 12;
    parameter int BYTE_W = 8;

    typedef struct packed {
        logic [YEAR_W-1:0] year;
        logic [3:0]        month;
        logic [4:0]        day;
        logic [4:0]        hour;
        logic [5:0]        minute;
        logic [5:0]        second;
    } cal_bin_t;

    typedef struct packed {
        logic              err;
        logic [BYTE_W-1:0] yr;
        logic [BYTE_W-1:0] mo;
        logic [BYTE_W-1:0] dy;
        logic [BYTE_W-1:0] hr;
        logic [BYTE_W-1:0] mi;
        logic [BYTE_W-1:0] se;
    } set_res_t;

    typedef struct packed {
        logic [7:0] yr_off;
        logic [3:0] mon0;
        logic [4:0] day;
        logic [4:0] hour;
        logic [5:0] minute;
        logic [5:0] second;
    } rd_res_t;

    function automatic logic [7:0] to_bcd(input logic [6:0] v);
        return {4'(v / 7'd10), 4'(v % 7'd10)};
    endfunction

    function automatic logic [7:0] from_bcd(input logic [7:0] b);
        return 8'(b[7:4]) * 8'd10 + 8'(b[3:0]);
    endfunction

endpackage

// File: rtl/cal_hs_stage.sv
module cal_hs_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);

    typedef enum logic {ST_EMPTY, ST_FULL} stage_st_t;

    stage_st_t st, st_nx;
    logic [W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_EMPTY;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_EMPTY: if (in_valid)  st_nx = ST_FULL;   // ACCEPT
            ST_FULL:  if (out_ready) st_nx = ST_EMPTY;  // RELEASE
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          data_q <= '0;
        else if (st == ST_EMPTY && in_valid) data_q <= in_data;
    end

    always_comb begin
        in_ready  = (st == ST_EMPTY);
        out_valid = (st == ST_FULL);
        out_data  = data_q;
    end

    p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid && !in_ready);

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    p_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |=> !out_valid && in_ready);

endmodule

// File: rtl/cal_set_check.sv
module cal_set_check
    import cal_pkg::*;
#(
    parameter int YEAR_LO = 1970
) (
    input  cal_bin_t t,
    output set_res_t r
);

    localparam int YEAR_HI = YEAR_LO + 99;
    localparam int CENT_LO = (YEAR_LO / 100) * 100;
    localparam int CENT_HI = CENT_LO + 100;
    localparam logic [YEAR_W-1:0] Y_LO  = YEAR_W'(YEAR_LO);
    localparam logic [YEAR_W-1:0] Y_HI  = YEAR_W'(YEAR_HI);
    localparam logic [YEAR_W-1:0] C_LO  = YEAR_W'(CENT_LO);
    localparam logic [YEAR_W-1:0] C_HI  = YEAR_W'(CENT_HI);

    logic        leap;
    logic [4:0]  mlen;
    logic        bad;
    logic [6:0]  yy;

    always_comb begin
        leap = ((t.year % YEAR_W'(4) == '0) && (t.year % YEAR_W'(100) != '0))
             || (t.year % YEAR_W'(400) == '0);

        unique case (t.month)
            4'd2:                      mlen = leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   mlen = 5'd30;
            default:                   mlen = 5'd31;
        endcase

        bad = (t.year < Y_LO) || (t.year > Y_HI)
            || (t.month == 4'd0) || (t.month > 4'd12)
            || (t.day == 5'd0) || (t.day > mlen)
            || (t.hour >= 5'd24)
            || (t.minute >= 6'd60) || (t.second >= 6'd60);

        yy = (t.year >= C_HI) ? 7'(t.year - C_HI) : 7'(t.year - C_LO);

        r.err = bad;
        r.yr  = bad ? '0 : to_bcd(yy);
        r.mo  = bad ? '0 : to_bcd(7'(t.month));
        r.dy  = bad ? '0 : to_bcd(7'(t.day));
        r.hr  = bad ? '0 : to_bcd(7'(t.hour));
        r.mi  = bad ? '0 : to_bcd(7'(t.minute));
        r.se  = bad ? '0 : to_bcd(7'(t.second));
    end

endmodule

// File: rtl/cal_read_decode.sv
module cal_read_decode
    import cal_pkg::*;
#(
    parameter int YEAR_LO = 1970,
    parameter int EPOCH   = 1900
) (
    input  logic [7:0] b_yr,
    input  logic [7:0] b_mo,
    input  logic [7:0] b_dy,
    input  logic [7:0] b_hr,
    input  logic [7:0] b_mi,
    input  logic [7:0] b_se,
    output rd_res_t    r
);

    localparam logic [7:0] PIVOT    = 8'(YEAR_LO % 100);
    localparam logic [7:0] CENT_ADJ = 8'((YEAR_LO / 100) * 100 - EPOCH);
    localparam logic [7:0] M_SECMIN = 8'h7F;
    localparam logic [7:0] M_HRDY   = 8'h3F;
    localparam logic [7:0] M_MON    = 8'h1F;

    logic [7:0] yr8, mo8, dy8, hr8, mi8, se8;

    always_comb begin
        yr8 = from_bcd(b_yr);
        mo8 = from_bcd(b_mo & M_MON);
        dy8 = from_bcd(b_dy & M_HRDY);
        hr8 = from_bcd(b_hr & M_HRDY);
        mi8 = from_bcd(b_mi & M_SECMIN);
        se8 = from_bcd(b_se & M_SECMIN);

        r.yr_off = yr8 + ((yr8 < PIVOT) ? 8'd100 : 8'd0) + CENT_ADJ;
        r.mon0   = 4'(mo8 - 8'd1);
        r.day    = 5'(dy8);
        r.hour   = 5'(hr8);
        r.minute = 6'(mi8);
        r.second = 6'(se8);
    end

endmodule

// File: rtl/cal_codec.sv
module cal_codec
    import cal_pkg::*;
#(
    parameter int YEAR_LO = 1970,
    parameter int EPOCH   = 1900
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_in_valid,
    output logic              set_in_ready,
    input  logic [YEAR_W-1:0] set_year,
    input  logic [3:0]        set_month,
    input  logic [4:0]        set_day,
    input  logic [4:0]        set_hour,
    input  logic [5:0]        set_minute,
    input  logic [5:0]        set_second,
    output logic              set_out_valid,
    input  logic              set_out_ready,
    output logic              set_err,
    output logic [7:0]        bcd_year,
    output logic [7:0]        bcd_month,
    output logic [7:0]        bcd_day,
    output logic [7:0]        bcd_hour,
    output logic [7:0]        bcd_minute,
    output logic [7:0]        bcd_second,
    input  logic              rd_in_valid,
    output logic              rd_in_ready,
    input  logic [7:0]        rd_year_bcd,
    input  logic [7:0]        rd_month_bcd,
    input  logic [7:0]        rd_day_bcd,
    input  logic [7:0]        rd_hour_bcd,
    input  logic [7:0]        rd_minute_bcd,
    input  logic [7:0]        rd_second_bcd,
    output logic              rd_out_valid,
    input  logic              rd_out_ready,
    output logic [7:0]        rd_year_off,
    output logic [3:0]        rd_month0,
    output logic [4:0]        rd_day,
    output logic [4:0]        rd_hour,
    output logic [5:0]        rd_minute,
    output logic [5:0]        rd_second
);

    localparam int SET_W = $bits(set_res_t);
    localparam int RD_W  = $bits(rd_res_t);

    cal_bin_t set_req;
    set_res_t set_comb, set_q;
    rd_res_t  rd_comb, rd_q;

    always_comb begin
        set_req.year   = set_year;
        set_req.month  = set_month;
        set_req.day    = set_day;
        set_req.hour   = set_hour;
        set_req.minute = set_minute;
        set_req.second = set_second;
    end

    cal_set_check #(.YEAR_LO(YEAR_LO)) u_check (
        .t (set_req),
        .r (set_comb)
    );

    cal_hs_stage #(.W(SET_W)) u_set_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (set_in_valid),
        .in_ready  (set_in_ready),
        .in_data   (set_comb),
        .out_valid (set_out_valid),
        .out_ready (set_out_ready),
        .out_data  (set_q)
    );

    cal_read_decode #(.YEAR_LO(YEAR_LO), .EPOCH(EPOCH)) u_decode (
        .b_yr (rd_year_bcd),
        .b_mo (rd_month_bcd),
        .b_dy (rd_day_bcd),
        .b_hr (rd_hour_bcd),
        .b_mi (rd_minute_bcd),
        .b_se (rd_second_bcd),
        .r    (rd_comb)
    );

    cal_hs_stage #(.W(RD_W)) u_rd_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rd_in_valid),
        .in_ready  (rd_in_ready),
        .in_data   (rd_comb),
        .out_valid (rd_out_valid),
        .out_ready (rd_out_ready),
        .out_data  (rd_q)
    );

    always_comb begin
        set_err     = set_q.err;
        bcd_year    = set_q.yr;
        bcd_month   = set_q.mo;
        bcd_day     = set_q.dy;
        bcd_hour    = set_q.hr;
        bcd_minute  = set_q.mi;
        bcd_second  = set_q.se;
        rd_year_off = rd_q.yr_off;
        rd_month0   = rd_q.mon0;
        rd_day      = rd_q.day;
        rd_hour     = rd_q.hour;
        rd_minute   = rd_q.minute;
        rd_second   = rd_q.second;
    end

    function automatic logic digits_ok(input logic [7:0] b);
        return (b[7:4] <= 4'd9) && (b[3:0] <= 4'd9);
    endfunction

    p_err_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_out_valid && set_err |->
            (bcd_year == 8'd0) && (bcd_month == 8'd0) && (bcd_day == 8'd0)
            && (bcd_hour == 8'd0) && (bcd_minute == 8'd0) && (bcd_second == 8'd0));

    p_bcd_digits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_out_valid && !set_err |->
            digits_ok(bcd_year) && digits_ok(bcd_month) && digits_ok(bcd_day)
            && digits_ok(bcd_hour) && digits_ok(bcd_minute) && digits_ok(bcd_second));

    p_legal_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_out_valid && !set_err |->
            (bcd_hour < 8'h24) && (bcd_minute < 8'h60) && (bcd_second < 8'h60)
            && (bcd_month != 8'h00) && (bcd_month <= 8'h12) && (bcd_day != 8'h00));

endmodule

// File: tb/cal_codec_test.sv
module cal_codec_test;
    import cal_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic              set_in_valid = 1'b0, set_out_ready = 1'b0;
    logic              set_in_ready, set_out_valid, set_err;
    logic [YEAR_W-1:0] set_year = '0;
    logic [3:0]        set_month = '0;
    logic [4:0]        set_day = '0, set_hour = '0;
    logic [5:0]        set_minute = '0, set_second = '0;
    logic [7:0]        bcd_year, bcd_month, bcd_day, bcd_hour, bcd_minute, bcd_second;
    logic              rd_in_valid = 1'b0, rd_out_ready = 1'b0;
    logic              rd_in_ready, rd_out_valid;
    logic [7:0]        rd_year_bcd = '0, rd_month_bcd = '0, rd_day_bcd = '0;
    logic [7:0]        rd_hour_bcd = '0, rd_minute_bcd = '0, rd_second_bcd = '0;
    logic [7:0]        rd_year_off;
    logic [3:0]        rd_month0;
    logic [4:0]        rd_day, rd_hour;
    logic [5:0]        rd_minute, rd_second;

    int n_checks = 0;
    int n_fail = 0;

    cal_codec uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] bcd8(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    task automatic do_set(input int y, input int mo, input int d, input int h,
                          input int mi, input int s, input logic exp_err, input string tag);
        logic [47:0] snap;
        int yy;
        set_year = YEAR_W'(y); set_month = 4'(mo); set_day = 5'(d);
        set_hour = 5'(h); set_minute = 6'(mi); set_second = 6'(s);
        set_in_valid = 1'b1; set_out_ready = 1'b0;
        @(posedge clk); #1;
        set_in_valid = 1'b0;
        chk({tag, " R1 valid"}, 32'(set_out_valid), 32'd1);
        chk({tag, " R1 busy"}, 32'(set_in_ready), 32'd0);
        chk({tag, " err"}, 32'(set_err), 32'(exp_err));
        yy = (y >= 2000) ? y - 2000 : y - 1900;
        if (exp_err) begin
            chk({tag, " R8 zero"},
                {8'd0, bcd_year, bcd_month, bcd_day} | {8'd0, bcd_hour, bcd_minute, bcd_second}, 32'd0);
        end else begin
            chk({tag, " R7 date"}, {8'd0, bcd_year, bcd_month, bcd_day},
                {8'd0, bcd8(yy), bcd8(mo), bcd8(d)});
            chk({tag, " R7 time"}, {8'd0, bcd_hour, bcd_minute, bcd_second},
                {8'd0, bcd8(h), bcd8(mi), bcd8(s)});
        end
        snap = {bcd_year, bcd_month, bcd_day, bcd_hour, bcd_minute, bcd_second};
        set_year = YEAR_W'(1234); set_second = 6'd7;
        @(posedge clk); #1;
        chk({tag, " R1 hold"}, 32'(set_out_valid), 32'd1);
        chk({tag, " R1 stable"}, 32'(snap == {bcd_year, bcd_month, bcd_day,
                                             bcd_hour, bcd_minute, bcd_second}), 32'd1);
        set_out_ready = 1'b1;
        @(posedge clk); #1;
        set_out_ready = 1'b0;
        chk({tag, " R1 release"}, {30'd0, set_out_valid, set_in_ready}, 32'b01);
    endtask

    task automatic do_read(input logic [7:0] by, input logic [7:0] bm, input logic [7:0] bd,
                           input logic [7:0] bh, input logic [7:0] bmi, input logic [7:0] bs,
                           input int ey, input int em, input int ed, input int eh,
                           input int emi, input int es, input string tag);
        rd_year_bcd = by; rd_month_bcd = bm; rd_day_bcd = bd;
        rd_hour_bcd = bh; rd_minute_bcd = bmi; rd_second_bcd = bs;
        rd_in_valid = 1'b1; rd_out_ready = 1'b0;
        @(posedge clk); #1;
        rd_in_valid = 1'b0;
        chk({tag, " R1 valid"}, 32'(rd_out_valid), 32'd1);
        chk({tag, " year"}, 32'(rd_year_off), 32'(ey));
        chk({tag, " month"}, 32'(rd_month0), 32'(em));
        chk({tag, " dhms"}, {8'd0, 3'd0, rd_day, 3'd0, rd_hour, 2'd0, rd_minute, 2'd0, rd_second},
            {8'd0, 3'd0, 5'(ed), 3'd0, 5'(eh), 2'd0, 6'(emi), 2'd0, 6'(es)});
        rd_out_ready = 1'b1;
        @(posedge clk); #1;
        rd_out_ready = 1'b0;
        chk({tag, " R1 release"}, {30'd0, rd_out_valid, rd_in_ready}, 32'b01);
    endtask

    task automatic t_reset();
        chk("R11 set idle", {30'd0, set_out_valid, set_in_ready}, 32'b01);
        chk("R11 rd idle", {30'd0, rd_out_valid, rd_in_ready}, 32'b01);
        chk("R11 set zero", {24'd0, bcd_year} | {31'd0, set_err}, 32'd0);
    endtask

    task automatic t_window();
        do_set(1970, 6, 15, 12, 30, 45, 1'b0, "R2 low edge");
        do_set(2069, 11, 30, 8, 5, 9, 1'b0, "R2 high edge");
        do_set(1969, 12, 31, 23, 59, 59, 1'b1, "R2 below");
        do_set(2070, 1, 1, 0, 0, 0, 1'b1, "R2 above");
    endtask

    task automatic t_fold();
        do_set(1999, 12, 31, 23, 59, 59, 1'b0, "R7 pre2000");
        do_set(2000, 1, 1, 0, 0, 0, 1'b0, "R7 fold2000");
    endtask

    task automatic t_month();
        do_set(2010, 0, 10, 1, 1, 1, 1'b1, "R3 month0");
        do_set(2010, 13, 10, 1, 1, 1, 1'b1, "R3 month13");
    endtask

    task automatic t_day();
        do_set(2010, 5, 0, 1, 1, 1, 1'b1, "R4 day0");
        do_set(2010, 4, 31, 1, 1, 1, 1'b1, "R4 apr31");
        do_set(2010, 1, 31, 1, 1, 1, 1'b0, "R4 jan31");
        do_set(2011, 2, 29, 1, 1, 1, 1'b1, "R4 feb29 plain");
    endtask

    task automatic t_leap();
        do_set(2000, 2, 29, 4, 4, 4, 1'b0, "R5 y2000");
        do_set(1972, 2, 29, 4, 4, 4, 1'b0, "R5 y1972");
        do_set(2001, 2, 29, 4, 4, 4, 1'b1, "R5 y2001");
        do_set(2000, 2, 30, 4, 4, 4, 1'b1, "R5 feb30");
    endtask

    task automatic t_clock_fields();
        do_set(2020, 3, 3, 24, 0, 0, 1'b1, "R6 hour24");
        do_set(2020, 3, 3, 0, 60, 0, 1'b1, "R6 min60");
        do_set(2020, 3, 3, 0, 0, 60, 1'b1, "R6 sec60");
    endtask

    task automatic t_readback();
        do_read(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59, 99, 11, 31, 23, 59, 59, "R9 y99");
        do_read(8'h69, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 169, 0, 1, 0, 0, 0, "R9 y69");
        do_read(8'h70, 8'h07, 8'h15, 8'h12, 8'h34, 8'h56, 70, 6, 15, 12, 34, 56, "R9 y70");
        do_read(8'h00, 8'h02, 8'h29, 8'h09, 8'h08, 8'h07, 100, 1, 29, 9, 8, 7, "R9 y00");
    endtask

    task automatic t_mask();
        do_read(8'h21, 8'hF2, 8'hF1, 8'hE3, 8'h80, 8'hD9, 121, 11, 31, 23, 0, 59, "R10 mask");
    endtask

    initial begin
        #(20 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_window();
        t_fold();
        t_month();
        t_day();
        t_leap();
        t_clock_fields();
        t_readback();
        t_mask();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule